// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with one tick counter that drives two deadlines. The counter first runs up to an interrupt timeout, chosen from four intervals by a two-bit select. When it gets there, a sticky flag sets and the interrupt output goes high if interrupts are enabled. The counter then starts a fixed reset-delay window. If software does not send a restart strobe before that window ends, the block produces a one-cycle reset request, provided reset generation is enabled. It also records the watchdog as the reset cause.

The clock input is the free-running oscillator tick. The interval select is loaded through a write strobe, and the system reset returns it to code 00. Writing a different code while the first stage is still counting starts the timing over. Writing a code during the reset window does not move the pending reset. The reset-cause flag sits on its own power-on reset. That way it survives the system reset it records, and software clears it with a separate strobe.

Top module: `wdt_two_stage`

## Requirements
- R1: The interrupt timeout is 2^(BASE_EXP + STEP_EXP*code) ticks. With the defaults, codes 00, 01, 10 and 11 give 2^12, 2^15, 2^18 and 2^21. flag_o rises on exactly that many clock edges after the edge that started the count.
- R2: rst_req_o goes high for exactly one cycle, 2^DLY_EXP ticks after the interrupt timeout (512 by default), if rst_en_i is high at that edge.
- R3: When rst_en_i is low at the end of the window, no reset request and no cause flag are produced. The block still stops counting.
- R4: flag_o sets at the timeout whatever int_en_i is, stays set until flag_clr_i, and a set takes priority over a clear on the same edge. irq_o is high exactly while flag_o and int_en_i are both high.
- R5: Deasserting rst_ni (active low) clears the counter and flag_o and returns the select to code 00. The next count then uses the code-00 interval.
- R6: During the first stage, a select write with a code different from the current one restarts the count under the new interval. A write of the same code changes nothing.
- R7: A select write during the reset window leaves the reset request on its original tick. The new code applies from the next restart.
- R8: restart_i clears the counter, cancels any pending reset window and returns the block to the first stage. This holds from any stage.
- R9: cause_o sets on the same edge as the reset request and is not cleared by rst_ni. Only cause_clr_i or por_ni clears it, and a set takes priority over a clear.
- R10: After the window ends, the counter holds. No further flag set or reset request occurs until a restart or a system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator tick clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| por_ni | input | 1 | Asynchronous power-on reset for the cause flag, active low |
| sel_i | input | SEL_W | Interval select code |
| sel_wr_i | input | 1 | Load strobe for sel_i |
| restart_i | input | 1 | Software restart strobe |
| int_en_i | input | 1 | Interrupt enable |
| rst_en_i | input | 1 | Reset request enable |
| flag_clr_i | input | 1 | Clears the timeout flag |
| cause_clr_i | input | 1 | Clears the reset-cause flag |
| irq_o | output | 1 | Interrupt, flag gated by enable |
| rst_req_o | output | 1 | One-cycle system reset request |
| flag_o | output | 1 | Sticky interrupt timeout flag |
| cause_o | output | 1 | Watchdog was the reset cause |

## Verification
The bench measures the exact edge counts to the flag and to the reset pulse for all four codes. A design that is off by one in either terminal compare reports a wrong count.

Several cases probe the select write:
- a different code written mid-count, where a design that keeps the old count fires early;
- the same code written mid-count, where a design that restarts anyway fires late;
- a code written inside the window, where a design that restarts moves or drops the reset.

Further cases cover:
- restart inside the window, where the reset must be cancelled;
- reset generation disabled, where a leaking pulse or cause flag shows up;
- a system reset after a watchdog reset, where a cause flag tied to rst_ni or a select that does not return to code 00 is caught.

Random traffic is compared every cycle against a reference model in the bench.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_COUNT  = 2'd0,
    PH_WINDOW = 2'd1,
    PH_HOLD   = 2'd2
  } wdt_phase_e;
endpackage

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned STEP_EXP = 3,
  parameter int unsigned CNT_W    = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sel_wr_i,
  output logic [CNT_W-1:0] term_o,
  output logic             sel_chg_o
);
  localparam int unsigned NCODES = 1 << SEL_W;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] term_tbl [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_term
    localparam int unsigned EXP_G = BASE_EXP + STEP_EXP * g;
    assign term_tbl[g] = {{(CNT_W - EXP_G){1'b0}}, {EXP_G{1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_wr_i) sel_q <= sel_i;
  end

  assign sel_chg_o = sel_wr_i && (sel_i != sel_q);
  assign term_o    = term_tbl[sel_q];

  p_sel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr_i |=> $stable(sel_q));
  p_sel_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> sel_q == $past(sel_i));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 22,
  parameter int unsigned DLY_EXP = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             sel_chg_i,
  input  logic [CNT_W-1:0] term_i,
  input  logic             rst_en_i,
  output logic             tmo_o,
  output logic             req_set_o,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] DLY_TERM = {{(CNT_W - DLY_EXP){1'b0}}, {DLY_EXP{1'b1}}};

  wdt_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q;
  logic             cnt_hit, dly_hit;

  assign cnt_hit = (cnt_q == term_i);
  assign dly_hit = (cnt_q == DLY_TERM);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    tmo_o     = 1'b0;
    req_set_o = 1'b0;
    if (restart_i) begin
      phase_d = PH_COUNT;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_COUNT: begin
          if (sel_chg_i) begin
            cnt_d = '0;
          end else if (cnt_hit) begin
            tmo_o   = 1'b1;
            cnt_d   = '0;
            phase_d = PH_WINDOW;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_WINDOW: begin
          if (dly_hit) begin
            req_set_o = rst_en_i;
            cnt_d     = '0;
            phase_d   = PH_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_COUNT;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      req_q   <= req_set_o;
    end
  end

  assign req_o = req_q;

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  p_win_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_WINDOW |-> cnt_q <= DLY_TERM);
  p_req_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(rst_en_i));
  p_selchg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_chg_i && !restart_i && phase_q == PH_COUNT) |=> cnt_q == '0);
  p_win_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WINDOW && !restart_i && !dly_hit) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_q == PH_COUNT && cnt_q == '0));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && !restart_i) |=> (phase_q == PH_HOLD && !req_q));
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic tmo_i,
  input  logic flag_clr_i,
  input  logic req_set_i,
  input  logic cause_clr_i,
  input  logic int_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic cause_o
);
  logic flag_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (tmo_i)      flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  // cause lives on the power-on reset so the system reset it records keeps it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)          cause_q <= 1'b0;
    else if (req_set_i)   cause_q <= 1'b1;
    else if (cause_clr_i) cause_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign irq_o   = flag_q & int_en_i;
  assign cause_o = cause_q;

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> flag_q);
  p_cause_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    req_set_i |=> cause_q);
  p_cause_keep_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (cause_q && !cause_clr_i) |=> cause_q);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned STEP_EXP = 3,
  parameter int unsigned DLY_EXP  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sel_wr_i,
  input  logic             restart_i,
  input  logic             int_en_i,
  input  logic             rst_en_i,
  input  logic             flag_clr_i,
  input  logic             cause_clr_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             flag_o,
  output logic             cause_o
);
  localparam int unsigned NCODES  = 1 << SEL_W;
  localparam int unsigned MAX_EXP = BASE_EXP + STEP_EXP * (NCODES - 1);
  localparam int unsigned CNT_W   = (MAX_EXP > DLY_EXP ? MAX_EXP : DLY_EXP) + 1;

  logic [CNT_W-1:0] term;
  logic             sel_chg, tmo, req_set;

  wdt_interval #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .CNT_W(CNT_W)
  ) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .sel_wr_i(sel_wr_i),
    .term_o(term), .sel_chg_o(sel_chg)
  );

  wdt_core #(.CNT_W(CNT_W), .DLY_EXP(DLY_EXP)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .sel_chg_i(sel_chg),
    .term_i(term), .rst_en_i(rst_en_i), .tmo_o(tmo), .req_set_o(req_set),
    .req_o(rst_req_o)
  );

  wdt_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .tmo_i(tmo),
    .flag_clr_i(flag_clr_i), .req_set_i(req_set), .cause_clr_i(cause_clr_i),
    .int_en_i(int_en_i), .flag_o(flag_o), .irq_o(irq_o), .cause_o(cause_o)
  );
endmodule

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  localparam int B = 4, S = 2, DE = 4;
  localparam int DLY = 1 << DE;

  logic clk = 0, rst_n = 0, por_n = 0;
  logic [1:0] sel = 0;
  logic sel_wr = 0, restart = 0, int_en = 0, rst_en = 1, flag_clr = 0, cause_clr = 0;
  logic irq, req, flag, cause;

  int checks = 0, errors = 0;
  bit cmp_en = 0, done = 0;

  always #2.5 clk = ~clk;

  wdt_two_stage #(.SEL_W(2), .BASE_EXP(B), .STEP_EXP(S), .DLY_EXP(DE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .sel_i(sel), .sel_wr_i(sel_wr),
    .restart_i(restart), .int_en_i(int_en), .rst_en_i(rst_en), .flag_clr_i(flag_clr),
    .cause_clr_i(cause_clr), .irq_o(irq), .rst_req_o(req), .flag_o(flag), .cause_o(cause)
  );

  function automatic int lim(input int c);
    return 1 << (B + S * c);
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // reference model
  int m_el, m_st, m_sel;
  bit m_flag, m_cause, m_req, set_f;
  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n || !rst_n) begin
      m_el = 0; m_st = 0; m_sel = 0; m_flag = 0; m_req = 0;
      if (!por_n) m_cause = 0;
    end else begin
      set_f = 0; m_req = 0;
      if (restart) begin
        m_el = 0; m_st = 0;
        if (sel_wr) m_sel = int'(sel);
      end else begin
        case (m_st)
          0: if (sel_wr && int'(sel) != m_sel) begin
               m_sel = int'(sel); m_el = 0;
             end else begin
               m_el++;
               if (m_el == lim(m_sel)) begin set_f = 1; m_st = 1; m_el = 0; end
             end
          1: begin
               if (sel_wr) m_sel = int'(sel);
               m_el++;
               if (m_el == DLY) begin m_req = rst_en; m_st = 2; end
             end
          default: if (sel_wr) m_sel = int'(sel);
        endcase
      end
      if (set_f) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (m_req) m_cause = 1; else if (cause_clr) m_cause = 0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_en && rst_n && por_n) begin
      check("R4 flag model", int'(flag), int'(m_flag));
      check("R4 irq model", int'(irq), int'(m_flag & int_en));
      check("R2 req model", int'(req), int'(m_req));
      check("R9 cause model", int'(cause), int'(m_cause));
    end
  end

  task automatic start(input int code);
    restart = 1; sel_wr = 1; sel = 2'(code); flag_clr = 1;
    @(negedge clk);
    restart = 0; sel_wr = 0; flag_clr = 0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!flag && n < 3000);
  endtask

  task automatic wait_req(output int n, output bit saw);
    n = 0; saw = 0;
    do begin @(negedge clk); n++; if (req) saw = 1; end while (!req && n < DLY + 8);
  endtask

  task automatic write_sel(input int code);
    sel_wr = 1; sel = 2'(code);
    @(negedge clk);
    sel_wr = 0;
  endtask

  initial begin
    int n; bit saw;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R5 reset flag", int'(flag), 0);
    check("R5 reset req", int'(req), 0);
    check("R9 reset cause", int'(cause), 0);
    check("R4 reset irq", int'(irq), 0);
    por_n = 1; rst_n = 1; cmp_en = 1;
    @(negedge clk);

    // R1/R2/R9 per code
    for (int c = 0; c < 4; c++) begin
      cause_clr = 1; @(negedge clk); cause_clr = 0;
      start(c);
      wait_flag(n);
      check($sformatf("R1 timeout code %0d", c), n, lim(c));
      wait_req(n, saw);
      check($sformatf("R2 delay code %0d", c), n, DLY);
      check("R9 cause with req", int'(cause), 1);
      @(negedge clk);
      check("R2 single pulse", int'(req), 0);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      saw = 0;
      repeat (2 * lim(0) + DLY) begin @(negedge clk); if (flag || req) saw = 1; end
      check("R10 hold after expiry", int'(saw), 0);
    end

    // R3: reset disabled
    cause_clr = 1; @(negedge clk); cause_clr = 0;
    rst_en = 0;
    start(0);
    wait_flag(n);
    check("R3 flag still sets", n, lim(0));
    wait_req(n, saw);
    check("R3 no request", int'(saw), 0);
    check("R3 no cause", int'(cause), 0);
    rst_en = 1;

    // R4: flag set with enable low, irq gating, clear
    int_en = 0;
    start(0);
    wait_flag(n);
    check("R4 irq gated off", int'(irq), 0);
    int_en = 1; #1;
    check("R4 irq with enable", int'(irq), 1);
    @(negedge clk);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R4 flag cleared", int'(flag), 0);

    // R6: different code mid-count restarts under new interval
    start(1);
    repeat (29) @(negedge clk);
    write_sel(0);
    wait_flag(n);
    check("R6 new code restarts count", n, lim(0));
    // R6: same code mid-count does nothing
    start(1);
    repeat (9) @(negedge clk);
    write_sel(1);
    wait_flag(n);
    check("R6 same code no restart", n, lim(1) - 10);

    // R8: restart mid-count postpones
    start(0);
    repeat (9) @(negedge clk);
    start(0);
    wait_flag(n);
    check("R8 restart postpones flag", n, lim(0));

    // R7: write in window keeps schedule, applies after restart
    repeat (4) @(negedge clk);
    write_sel(3);
    wait_req(n, saw);
    check("R7 req on schedule", n, DLY - 5);
    start(3);
    wait_flag(n);
    check("R7 new code after restart", n, lim(3));

    // R8: restart in window cancels reset
    repeat (7) @(negedge clk);
    start(0);
    n = 0; saw = 0;
    do begin @(negedge clk); n++; if (req) saw = 1; end while (!flag && n < 3000);
    check("R8 window cancelled", int'(saw), 0);
    check("R8 count from restart", n, lim(0));
    wait_req(n, saw);
    check("R8 req after new window", n, DLY);

    // R5/R9: system reset keeps cause, select back to 00
    write_sel(2);
    rst_n = 0; @(negedge clk);
    check("R9 cause survives system reset", int'(cause), 1);
    check("R5 flag cleared", int'(flag), 0);
    rst_n = 1;
    wait_flag(n);
    check("R5 select defaults to 00", n, lim(0));

    // random traffic against the model
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      restart   = ($urandom % 96) == 0;
      sel_wr    = ($urandom % 40) == 0;
      sel       = (($urandom % 4) == 0) ? 2'($urandom % 2) : 2'd0;
      int_en    = 1'($urandom);
      rst_en    = ($urandom % 5) != 0;
      flag_clr  = ($urandom % 16) == 0;
      cause_clr = ($urandom % 48) == 0;
    end
    @(negedge clk);
    restart = 0; sel_wr = 0; flag_clr = 0; cause_clr = 0; rst_en = 1;

    // R9: power-on reset clears cause
    start(0);
    wait_flag(n);
    wait_req(n, saw);
    check("R9 cause before por", int'(cause), 1);
    cmp_en = 0;
    por_n = 0; rst_n = 0; @(negedge clk);
    check("R9 por clears cause", int'(cause), 0);
    por_n = 1; rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule